// File: doc/BRIEF.md
# Packed Vector Integer Multiply Unit

This unit multiplies two 128-bit vectors lane by lane. A 4-bit operation code picks the lane width (16, 32 or 64 bits) and which part of each product is kept: the low half, the high half of a signed product, or the high half of an unsigned product. Two widening operations form full 64-bit products from the even-numbered 32-bit lanes only. All lanes use one layout: lane 0 sits in the least significant bits of both operands and of the result, and lane k starts at bit k times the lane width.

The unit has a three-stage pipeline with a valid/ready handshake. It accepts one operation on every clock when the consumer is ready. When the consumer holds ready low, every stage freezes together, so the operation already at the output stays there, unchanged, until it is taken. An operation code outside the defined set does not stop the pipeline. It produces a zeroed result, and an error flag travels with that result.

Top module: `simd_mul_unit`

## Requirements
- R1: Code 0 treats the operands as eight 16-bit lanes (lane k in bits 16k+15 down to 16k) and returns the low 16 bits of each lane's product.
- R2: Code 1 returns the high 16 bits of each 16-bit lane's product with both inputs taken as two's complement. Code 2 does the same with both inputs taken as unsigned.
- R3: Code 3 treats the operands as four 32-bit lanes (lane k in bits 32k+31 down to 32k) and returns the low 32 bits of each lane's product.
- R4: Code 4 returns the high 32 bits of each signed 32-bit lane product. Code 5 returns the high 32 bits of each unsigned 32-bit lane product.
- R5: Code 6 (signed) and code 7 (unsigned) multiply 32-bit lane 0 and 32-bit lane 2 into full 64-bit products. The lane 0 product goes to result bits 63:0 and the lane 2 product to bits 127:64. Lanes 1 and 3 of both operands have no effect.
- R6: Code 8 treats the operands as two 64-bit lanes (lane k in bits 64k+63 down to 64k) and returns the low 64 bits of each product.
- R7: An operation accepted at a clock edge (inValid and inReady both high) appears on the outputs after the third edge, counting that edge, if outReady stays high. Back-to-back operations come out one per cycle, in order, and none is lost.
- R8: inReady equals outReady. While outReady is low, every stage holds, and a pending output keeps outValid, result and errOut unchanged.
- R9: Codes 9 to 15 give an all-zero result with errOut high on that operation's output beat. errOut is low on every beat of a defined code and whenever outValid is low.
- R10: During reset and directly after it, outValid and errOut are low and result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | An operation is offered on opA, opB and opCode |
| inReady | output | 1 | The unit takes the offered operation at this edge |
| opA | input | 128 | First vector operand |
| opB | input | 128 | Second vector operand |
| opCode | input | 4 | Operation select, codes as in R1 to R9 |
| outValid | output | 1 | result and errOut carry a finished operation |
| outReady | input | 1 | The consumer takes the output beat at this edge |
| result | output | 128 | Packed product vector |
| errOut | output | 1 | The beat on the outputs came from an undefined code |

## Verification
The hardest case to reach is an operation that is still inside the pipeline when outReady drops. A stall there must leave the earlier stages intact as well as the output stage, and it must not duplicate or drop any beat when the flow starts again. To get there, the bench streams operations while it drops outReady and inValid at random, and checks every output beat in order against an arithmetic model. It also checks that a stalled beat stays exactly as it was until the consumer takes it. The signed and unsigned high halves differ only when the sign bits are set, so the sweep pairs every operation code with every combination of corner operands, such as the most negative value, all ones and one, before it adds random vectors.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

  typedef enum logic [3:0] {
    OP_M16_LO   = 4'd0,
    OP_M16_HI_S = 4'd1,
    OP_M16_HI_U = 4'd2,
    OP_M32_LO   = 4'd3,
    OP_M32_HI_S = 4'd4,
    OP_M32_HI_U = 4'd5,
    OP_WIDE_S   = 4'd6,
    OP_WIDE_U   = 4'd7,
    OP_M64_LO   = 4'd8
  } opCode_e;

  typedef enum logic [1:0] {
    K16   = 2'd0,
    K32   = 2'd1,
    KWIDE = 2'd2,
    K64   = 2'd3
  } laneKind_e;

  typedef struct packed {
    laneKind_e kind;
    logic      signedOp;
    logic      highHalf;
    logic      bad;
  } opCfg_t;

  typedef struct packed {
    logic      advance;
    logic      signedS1;
    laneKind_e kindS2;
    logic      highS2;
    logic      badS2;
  } dpStrobe_t;

  function automatic opCfg_t decodeOp(input logic [3:0] code);
    opCfg_t c;
    c = '{kind: K16, signedOp: 1'b0, highHalf: 1'b0, bad: 1'b0};
    case (code)
      OP_M16_LO:   c.kind = K16;
      OP_M16_HI_S: begin c.kind = K16; c.highHalf = 1'b1; c.signedOp = 1'b1; end
      OP_M16_HI_U: begin c.kind = K16; c.highHalf = 1'b1; end
      OP_M32_LO:   c.kind = K32;
      OP_M32_HI_S: begin c.kind = K32; c.highHalf = 1'b1; c.signedOp = 1'b1; end
      OP_M32_HI_U: begin c.kind = K32; c.highHalf = 1'b1; end
      OP_WIDE_S:   begin c.kind = KWIDE; c.signedOp = 1'b1; end
      OP_WIDE_U:   c.kind = KWIDE;
      OP_M64_LO:   c.kind = K64;
      default:     c.bad = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/simd_mul_ctrl.sv
module simd_mul_ctrl
  import simd_mul_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [3:0]      opCode,
  input  logic            outReady,
  output logic            inReady,
  output logic            outValid,
  output logic            errOut,
  output dpStrobe_t       strobe
);

  localparam int STAGES = 3;

  logic [STAGES-1:0] vldPipe;
  opCfg_t            cfgS1;
  laneKind_e         kindS2;
  logic              highS2;
  logic              badS2;
  logic              badS3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldPipe <= '0;
      cfgS1   <= '{kind: K16, signedOp: 1'b0, highHalf: 1'b0, bad: 1'b0};
      kindS2  <= K16;
      highS2  <= 1'b0;
      badS2   <= 1'b0;
      badS3   <= 1'b0;
    end else if (outReady) begin
      vldPipe <= {vldPipe[STAGES-2:0], inValid};
      cfgS1   <= decodeOp(opCode);
      kindS2  <= cfgS1.kind;
      highS2  <= cfgS1.highHalf;
      badS2   <= cfgS1.bad;
      badS3   <= badS2;
    end
  end

  assign inReady  = outReady;
  assign outValid = vldPipe[STAGES-1];
  assign errOut   = vldPipe[STAGES-1] & badS3;

  always_comb begin
    strobe.advance  = outReady;
    strobe.signedS1 = cfgS1.signedOp;
    strobe.kindS2   = kindS2;
    strobe.highS2   = highS2;
    strobe.badS2    = badS2;
  end

endmodule

// File: rtl/simd_mul_dp.sv
module simd_mul_dp
  import simd_mul_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] result
);

  localparam int N16 = VEC_W / 16;
  localparam int N32 = VEC_W / 32;
  localparam int N64 = VEC_W / 64;

  logic [VEC_W-1:0] aS1, bS1;
  logic [N16*32-1:0] p16d, p16q;
  logic [N32*64-1:0] p32d, p32q;
  logic [N64*64-1:0] p64d, p64q;
  logic [VEC_W-1:0]  nextRes;

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aS1 <= '0;
      bS1 <= '0;
    end else if (strobe.advance) begin
      aS1 <= opA;
      bS1 <= opB;
    end
  end

  // stage 2 inputs: lane products for every width
  for (genvar g = 0; g < N16; g++) begin : gLane16
    logic [33:0] extA, extB, prod;
    assign extA = {{18{strobe.signedS1 & aS1[16*g+15]}}, aS1[16*g +: 16]};
    assign extB = {{18{strobe.signedS1 & bS1[16*g+15]}}, bS1[16*g +: 16]};
    assign prod = extA * extB;
    assign p16d[32*g +: 32] = prod[31:0];
  end

  for (genvar g = 0; g < N32; g++) begin : gLane32
    logic [63:0] extA, extB;
    assign extA = {{32{strobe.signedS1 & aS1[32*g+31]}}, aS1[32*g +: 32]};
    assign extB = {{32{strobe.signedS1 & bS1[32*g+31]}}, bS1[32*g +: 32]};
    assign p32d[64*g +: 64] = extA * extB;
  end

  for (genvar g = 0; g < N64; g++) begin : gLane64
    assign p64d[64*g +: 64] = aS1[64*g +: 64] * bS1[64*g +: 64];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p16q <= '0;
      p32q <= '0;
      p64q <= '0;
    end else if (strobe.advance) begin
      p16q <= p16d;
      p32q <= p32d;
      p64q <= p64d;
    end
  end

  // stage 3: half selection and packing
  always_comb begin
    nextRes = '0;
    case (strobe.kindS2)
      K16: begin
        for (int i = 0; i < N16; i++) begin
          nextRes[16*i +: 16] = strobe.highS2 ? p16q[32*i+16 +: 16] : p16q[32*i +: 16];
        end
      end
      K32: begin
        for (int i = 0; i < N32; i++) begin
          nextRes[32*i +: 32] = strobe.highS2 ? p32q[64*i+32 +: 32] : p32q[64*i +: 32];
        end
      end
      KWIDE: begin
        for (int j = 0; j < N64; j++) begin
          nextRes[64*j +: 64] = p32q[128*j +: 64];
        end
      end
      default: nextRes = p64q;
    endcase
    if (strobe.badS2) nextRes = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
    end else if (strobe.advance) begin
      result <= nextRes;
    end
  end

endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
  import simd_mul_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [3:0]       opCode,
  output logic             outValid,
  input  logic             outReady,
  output logic [VEC_W-1:0] result,
  output logic             errOut
);

  dpStrobe_t strobe;

  simd_mul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .errOut   (errOut),
    .strobe   (strobe)
  );

  simd_mul_dp #(.VEC_W(VEC_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/simd_mul_chk.sv
module simd_mul_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [VEC_W-1:0] result,
  input logic             errOut
);

  // R8: a beat held by the consumer does not change
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(result) && $stable(errOut)));

  // R9: the error flag comes only with a valid, zeroed beat
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> (outValid && (result == '0)));

  // R7: an accepted operation reaches the output three edges later when never stalled
  a_r7_latency: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 3) && $past(rstN, 2) && $past(rstN, 1) &&
     $past(inValid && inReady, 3) && $past(outReady, 2) && $past(outReady, 1))
    |-> outValid);

  // R10: nothing is presented on the first edge after reset
  a_r10_idle_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!outValid && !errOut && (result == '0)));

endmodule

bind simd_mul_unit simd_mul_chk #(.VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .result   (result),
  .errOut   (errOut)
);

// File: tb/sim_simd_mul_unit.sv
`timescale 1ns/1ps
module sim_simd_mul_unit;

  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [VW-1:0] opA = '0;
  logic [VW-1:0] opB = '0;
  logic [3:0]    opCode = '0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [VW-1:0] result;
  logic          errOut;

  int checks = 0;
  int fails  = 0;

  logic [132:0]  expQ[$];
  logic          holdPending = 1'b0;
  logic [VW-1:0] heldRes;
  logic          heldErr;

  always #2.5 clk = ~clk;

  simd_mul_unit #(.VEC_W(VW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .opCode(opCode), .outValid(outValid),
    .outReady(outReady), .result(result), .errOut(errOut)
  );

  function automatic string reqOf(input logic [3:0] m);
    case (m)
      4'd0:       return "R1";
      4'd1, 4'd2: return "R2";
      4'd3:       return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8:       return "R6";
      default:    return "R9";
    endcase
  endfunction

  // arithmetic model: {err, result}
  function automatic logic [VW:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                        input logic [3:0] m);
    logic [VW-1:0] r;
    logic [63:0]   x, y, p;
    logic          e;
    r = '0;
    e = 1'b0;
    case (m)
      4'd0, 4'd1, 4'd2: begin
        for (int i = 0; i < 8; i++) begin
          x = (m == 4'd1) ? {{48{a[16*i+15]}}, a[16*i +: 16]} : {48'd0, a[16*i +: 16]};
          y = (m == 4'd1) ? {{48{b[16*i+15]}}, b[16*i +: 16]} : {48'd0, b[16*i +: 16]};
          p = x * y;
          r[16*i +: 16] = (m == 4'd0) ? p[15:0] : p[31:16];
        end
      end
      4'd3, 4'd4, 4'd5: begin
        for (int i = 0; i < 4; i++) begin
          x = (m == 4'd4) ? {{32{a[32*i+31]}}, a[32*i +: 32]} : {32'd0, a[32*i +: 32]};
          y = (m == 4'd4) ? {{32{b[32*i+31]}}, b[32*i +: 32]} : {32'd0, b[32*i +: 32]};
          p = x * y;
          r[32*i +: 32] = (m == 4'd3) ? p[31:0] : p[63:32];
        end
      end
      4'd6, 4'd7: begin
        for (int j = 0; j < 2; j++) begin
          x = (m == 4'd6) ? {{32{a[64*j+31]}}, a[64*j +: 32]} : {32'd0, a[64*j +: 32]};
          y = (m == 4'd6) ? {{32{b[64*j+31]}}, b[64*j +: 32]} : {32'd0, b[64*j +: 32]};
          r[64*j +: 64] = x * y;
        end
      end
      4'd8: begin
        for (int j = 0; j < 2; j++) r[64*j +: 64] = a[64*j +: 64] * b[64*j +: 64];
      end
      default: e = 1'b1;
    endcase
    return {e, r};
  endfunction

  function automatic logic [VW-1:0] corner(input int k);
    case (k)
      0: return '0;
      1: return '1;
      2: return {8{16'h8000}};
      3: return {8{16'h7FFF}};
      4: return {4{32'h8000_0000}};
      5: return {2{64'h8000_0000_0000_0000}};
      6: return {8{16'h0001}};
      default: return {4{32'h7FFF_FFFF}};
    endcase
  endfunction

  function automatic logic [VW-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic note(input bit ok, input string req, input string what,
                      input logic [VW:0] act, input logic [VW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock of traffic: drive at the falling edge, then judge what the next rising edge will do
  task automatic cycle(input logic v, input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [3:0] m, input logic r);
    logic [132:0] e;
    @(negedge clk);
    if (holdPending)
      note(outValid && result == heldRes && errOut == heldErr, "R8", "stalled beat changed",
           {errOut, result}, {heldErr, heldRes});
    inValid = v; opA = a; opB = b; opCode = m; outReady = r;
    #1;
    note(inReady == r, "R8", "inReady vs outReady", {128'd0, inReady}, {128'd0, r});
    if (outValid && r) begin
      if (expQ.size() == 0) begin
        note(1'b0, "R7", "unexpected output beat", {errOut, result}, '0);
      end else begin
        e = expQ.pop_front();
        note({errOut, result} == e[128:0], reqOf(e[132:129]), "lane products",
             {errOut, result}, e[128:0]);
      end
    end
    holdPending = outValid && !r;
    heldRes = result;
    heldErr = errOut;
    if (v && inReady) expQ.push_back({m, model(a, b, m)});
  endtask

  task automatic drain();
    for (int k = 0; k < 20 && expQ.size() != 0; k++) cycle(1'b0, '0, '0, 4'd0, 1'b1);
    note(expQ.size() == 0, "R7", "beats missing after drain", VW'(expQ.size()), '0);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R10: reset state, while still held in reset and just after release
    note(!outValid && !errOut && result == '0, "R10", "state in reset",
         {errOut, result}, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    note(!outValid && !errOut && result == '0, "R10", "state after reset",
         {errOut, result}, '0);

    // R7: latency of a single operation is three edges
    cycle(1'b1, {8{16'h0003}}, {8{16'h0005}}, 4'd0, 1'b1);
    lat = 0;
    for (int k = 0; k < 8; k++) begin
      cycle(1'b0, '0, '0, 4'd0, 1'b1);
      lat++;
      if (outValid) break;
    end
    note(lat == 3, "R7", "latency", VW'(lat), VW'(3));
    drain();

    // R1..R6, R9: every code against every corner pair, full throughput
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          cycle(1'b1, corner(i), corner(j), 4'(m), 1'b1);
      for (int k = 0; k < 24; k++) cycle(1'b1, rnd(), rnd(), 4'(m), 1'b1);
    end
    drain();

    // R5: odd 32-bit lanes do not matter for the widening codes
    for (int k = 0; k < 16; k++) begin
      logic [VW-1:0] a, b;
      a = rnd(); b = rnd();
      cycle(1'b1, a, b, 4'd6, 1'b1);
      cycle(1'b1, a ^ {32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 32'd0}, b, 4'd6, 1'b1);
      cycle(1'b1, a, b ^ {32'h1234_5678, 32'd0, 32'h9ABC_DEF0, 32'd0}, 4'd7, 1'b1);
    end
    drain();

    // R8: random stalls and bubbles with mixed codes
    for (int k = 0; k < 1500; k++)
      cycle(($urandom % 4) != 0, rnd(), rnd(), 4'($urandom % 16), ($urandom % 3) != 0);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL R7 watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule